// File: doc/BRIEF.md
# Performance Monitor Control and Overflow Interrupt Block

This block holds the software-visible control state for a small bank of event counters and one dedicated cycle counter. A control word carries a global enable, two long-overflow selects, two self-clearing reset-action bits and a read-only field that reports how many event counters exist. Three per-counter masks sit beside it: counter enable, overflow status and interrupt enable. Each mask has a set address (write 1 to set) and a clear address (write 1 to clear).

The counting datapath reads the gated enables and the overflow width selects, receives the reset pulses, and reports counter wraps back on a per-counter overflow input. The block combines global enable with the overflow, enable and interrupt-enable masks into a single interrupt line. A separate probe port checks a counter index against the implemented count and flags indices that name no counter.

Top module: `pmu_ctl_top`

## Requirements
- R1: After reset the control word reads back only the counter-count field, all three masks read zero, and `ovf_irq`, `cnt_active`, `evt_long`, `cyc_long`, `evt_reset`, `cyc_reset` and `acc_err` are 0.
- R2: `cnt_active[i]` is 1 exactly when control bit 0 (global enable) is 1 and bit i of the enable mask is 1.
- R3: `ovf_irq` is 1 exactly when global enable is 1 and the AND of the overflow, enable and interrupt-enable masks is nonzero; with global enable 0 it stays 0 whatever the masks hold.
- R4: Control bits [12:8] read as `NUM_EVT` and ignore writes.
- R5: Control bits 1 (event-counter reset) and 2 (cycle-counter reset) always read as 0; writing 1 to bit 1 raises `evt_reset` and writing 1 to bit 2 raises `cyc_reset`, each for exactly the one cycle after the write edge.
- R6: Control bit 3 drives `evt_long` (wide overflow for event counters) and control bit 4 drives `cyc_long` (wide overflow for the cycle counter); both are stored and read back.
- R7: Address map: 0 control, 1/2 enable set/clear, 3/4 overflow set/clear, 5/6 interrupt-enable set/clear. A write to a set address sets each mask bit written as 1; a write to a clear address clears each mask bit written as 1; other bits are kept. Reads of either address of a pair return that mask.
- R8: Mask bits at index `NUM_EVT` and above, other than bit 31 (the cycle counter), never become 1 through writes or through `hw_ovf`.
- R9: An `acc_req` with `acc_idx` >= `NUM_EVT` and not equal to 31 makes `acc_err` 1 in the following cycle; any other index, or no request, gives 0.
- R10: A 1 on `hw_ovf[i]` for a legal bit i sets overflow-mask bit i at that clock edge, and wins over a clear written in the same cycle.
- R11: Read data appears on `reg_rdata` the cycle after `reg_re`; address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| hw_ovf | input | 32 | Per-counter wrap reports from the datapath |
| acc_req | input | 1 | Index probe request |
| acc_idx | input | 5 | Counter index to validate |
| acc_err | output | 1 | Probed index names no counter |
| cnt_active | output | 32 | Per-counter count enables after global gating |
| evt_long | output | 1 | Event counters overflow at 64 bits |
| cyc_long | output | 1 | Cycle counter overflows at 64 bits |
| evt_reset | output | 1 | One-cycle event-counter reset pulse |
| cyc_reset | output | 1 | One-cycle cycle-counter reset pulse |
| ovf_irq | output | 1 | Combined overflow interrupt |

## Verification
Register state, the gated enables, the width selects and the interrupt all follow a write one clock edge later, so every write is issued on a falling edge and its effect sampled on the next falling edge. Read data, the reset pulses and the index error come from one register each and are therefore sampled on the falling edge right after the strobe's rising edge; the pulses are sampled once more a cycle later to show they have dropped. Overflow reports from the datapath are held for one cycle and read back through the overflow mask address.

// File: rtl/pmu_ctl_pkg.sv
package pmu_ctl_pkg;
   localparam int MASK_W  = 32;
   localparam int CYC_IDX = 31;
   localparam int IDX_W   = 5;

   typedef enum logic [2:0] {
      A_CTRL    = 3'd0,
      A_EN_SET  = 3'd1,
      A_EN_CLR  = 3'd2,
      A_OVF_SET = 3'd3,
      A_OVF_CLR = 3'd4,
      A_IE_SET  = 3'd5,
      A_IE_CLR  = 3'd6,
      A_SPARE   = 3'd7
   } reg_addr_e;

   localparam int B_EN       = 0;
   localparam int B_EVT_RST  = 1;
   localparam int B_CYC_RST  = 2;
   localparam int B_LONG_EVT = 3;
   localparam int B_LONG_CYC = 4;
   localparam int N_LSB      = 8;
   localparam int N_W        = 5;

   function automatic logic [MASK_W-1:0] legal_mask(input int n);
      logic [MASK_W-1:0] m;
      m = '0;
      for (int i = 0; i < CYC_IDX; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      m[CYC_IDX] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg
   import pmu_ctl_pkg::*;
#(
   parameter int                W     = MASK_W,
   parameter logic [W-1:0]      LEGAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] set_bits, clr_bits, q_nxt;

   always_comb begin
      set_bits = set_we ? wdata : '0;
      clr_bits = clr_we ? wdata : '0;
      // hardware reports win over a software clear in the same cycle
      q_nxt    = ((q & ~clr_bits) | set_bits | hw_set) & LEGAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   AST_W1S_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(wdata & LEGAL)) == $past(wdata & LEGAL))); // R7
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && hw_set == '0) |=> ((q & $past(wdata)) == '0)); // R7
   AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((q & $past(hw_set & LEGAL)) == $past(hw_set & LEGAL))); // R10
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
   import pmu_ctl_pkg::*;
#(
   parameter int NUM_EVT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [4:0]        wdata,
   output logic [MASK_W-1:0] rd_word,
   output logic              glob_en,
   output logic              long_evt,
   output logic              long_cyc,
   output logic              evt_rst_p,
   output logic              cyc_rst_p
);
   localparam logic [N_W-1:0] N_FIELD = N_W'(NUM_EVT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en   <= 1'b0;
         long_evt  <= 1'b0;
         long_cyc  <= 1'b0;
         evt_rst_p <= 1'b0;
         cyc_rst_p <= 1'b0;
      end else begin
         evt_rst_p <= we & wdata[B_EVT_RST];
         cyc_rst_p <= we & wdata[B_CYC_RST];
         if (we) begin
            glob_en  <= wdata[B_EN];
            long_evt <= wdata[B_LONG_EVT];
            long_cyc <= wdata[B_LONG_CYC];
         end
      end
   end

   always_comb begin
      rd_word                     = '0;
      rd_word[B_EN]               = glob_en;
      rd_word[B_LONG_EVT]         = long_evt;
      rd_word[B_LONG_CYC]         = long_cyc;
      rd_word[N_LSB +: N_W]       = N_FIELD;
   end

   AST_EVT_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rst_p |-> $past(we && wdata[B_EVT_RST])); // R5
   AST_CYC_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_rst_p |-> $past(we && wdata[B_CYC_RST])); // R5
   AST_LONG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(long_evt) && $stable(long_cyc))); // R6
endmodule

// File: rtl/pmu_idx_chk.sv
module pmu_idx_chk
   import pmu_ctl_pkg::*;
#(
   parameter int NUM_EVT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [IDX_W-1:0] idx,
   output logic             err
);
   localparam logic [IDX_W-1:0] CYC_L = IDX_W'(CYC_IDX);
   logic bad;

   generate
      if (NUM_EVT == 0) begin : g_cyc_only
         assign bad = (idx != CYC_L);
      end else begin : g_range
         localparam logic [IDX_W-1:0] N_L = IDX_W'(NUM_EVT);
         assign bad = (idx >= N_L) && (idx != CYC_L);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= req & bad;
   end

   AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(req)); // R9
   AST_CYC_IDX_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (req && idx == CYC_L) |=> !err); // R9
endmodule

// File: rtl/pmu_ctl_top.sv
module pmu_ctl_top
   import pmu_ctl_pkg::*;
#(
   parameter int NUM_EVT = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_re,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [31:0] hw_ovf,
   input  logic        acc_req,
   input  logic [4:0]  acc_idx,
   output logic        acc_err,
   output logic [31:0] cnt_active,
   output logic        evt_long,
   output logic        cyc_long,
   output logic        evt_reset,
   output logic        cyc_reset,
   output logic        ovf_irq
);
   localparam logic [MASK_W-1:0] LEGAL = legal_mask(NUM_EVT);

   generate
      if (NUM_EVT < 0 || NUM_EVT > CYC_IDX) begin : g_bad_cfg
         $error("NUM_EVT must lie in 0..31");
      end
   endgenerate

   logic              glob_en;
   logic [MASK_W-1:0] ctrl_word, en_q, ovf_q, ie_q, rd_nxt, pend;

   pmu_ctrl_reg #(.NUM_EVT(NUM_EVT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we && reg_addr == A_CTRL),
      .wdata     (reg_wdata[4:0]),
      .rd_word   (ctrl_word),
      .glob_en   (glob_en),
      .long_evt  (evt_long),
      .long_cyc  (cyc_long),
      .evt_rst_p (evt_reset),
      .cyc_rst_p (cyc_reset)
   );

   pmu_mask_reg #(.W(MASK_W), .LEGAL(LEGAL)) u_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_EN_SET),
      .clr_we(reg_we && reg_addr == A_EN_CLR),
      .wdata(reg_wdata), .hw_set('0), .q(en_q)
   );

   pmu_mask_reg #(.W(MASK_W), .LEGAL(LEGAL)) u_ovf (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_OVF_SET),
      .clr_we(reg_we && reg_addr == A_OVF_CLR),
      .wdata(reg_wdata), .hw_set(hw_ovf), .q(ovf_q)
   );

   pmu_mask_reg #(.W(MASK_W), .LEGAL(LEGAL)) u_ie (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_IE_SET),
      .clr_we(reg_we && reg_addr == A_IE_CLR),
      .wdata(reg_wdata), .hw_set('0), .q(ie_q)
   );

   pmu_idx_chk #(.NUM_EVT(NUM_EVT)) u_idx (
      .clk(clk), .rst_n(rst_n), .req(acc_req), .idx(acc_idx), .err(acc_err)
   );

   always_comb begin
      cnt_active = glob_en ? en_q : '0;
      pend       = glob_en ? (ovf_q & en_q & ie_q) : '0;
      ovf_irq    = |pend;
   end

   always_comb begin
      unique case (reg_addr)
         A_CTRL:               rd_nxt = ctrl_word;
         A_EN_SET,  A_EN_CLR:  rd_nxt = en_q;
         A_OVF_SET, A_OVF_CLR: rd_nxt = ovf_q;
         A_IE_SET,  A_IE_CLR:  rd_nxt = ie_q;
         default:              rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_re) reg_rdata <= rd_nxt;
   end

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> glob_en); // R3
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ((ie_q & ovf_q) != '0)); // R3
   AST_ACTIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_active != '0) |-> glob_en); // R2
   AST_RESET_BITS_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == A_CTRL) |=> (reg_rdata[2:1] == 2'b00)); // R5
   AST_N_FIELD_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == A_CTRL) |=> (reg_rdata[12:8] == 5'(NUM_EVT))); // R4
endmodule

// File: tb/pmu_ctl_top_tb.sv
module pmu_ctl_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] hw_ovf = '0;
   logic        acc_req = 1'b0;
   logic [4:0]  acc_idx = '0;
   logic        acc_err;
   logic [31:0] cnt_active;
   logic        evt_long, cyc_long, evt_reset, cyc_reset, ovf_irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] rd;

   always #5 clk = ~clk;

   pmu_ctl_top #(.NUM_EVT(6)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hw_ovf(hw_ovf), .acc_req(acc_req), .acc_idx(acc_idx), .acc_err(acc_err),
      .cnt_active(cnt_active), .evt_long(evt_long), .cyc_long(cyc_long),
      .evt_reset(evt_reset), .cyc_reset(cyc_reset), .ovf_irq(ovf_irq)
   );

   // {is_write, addr, wdata, expected read}
   localparam logic [67:0] VEC [16] = '{
      {1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0},
      {1'b0, 3'd0, 32'h0,         32'h0000_0619},  // R4 R5 R6
      {1'b1, 3'd0, 32'h0000_1F00, 32'h0},
      {1'b0, 3'd0, 32'h0,         32'h0000_0600},  // R4
      {1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0},
      {1'b0, 3'd1, 32'h0,         32'h8000_003F},  // R8
      {1'b1, 3'd2, 32'h0000_0005, 32'h0},
      {1'b0, 3'd2, 32'h0,         32'h8000_003A},  // R7
      {1'b1, 3'd5, 32'h0000_0100, 32'h0},
      {1'b0, 3'd5, 32'h0,         32'h0000_0000},  // R8
      {1'b1, 3'd5, 32'h8000_0002, 32'h0},
      {1'b0, 3'd6, 32'h0,         32'h8000_0002},  // R7
      {1'b1, 3'd3, 32'h0000_0003, 32'h0},
      {1'b0, 3'd4, 32'h0,         32'h0000_0003},  // R7
      {1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0},
      {1'b0, 3'd7, 32'h0,         32'h0000_0000}   // R11
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_re = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_re = 1'b0;
      d = reg_rdata;
   endtask

   task automatic probe(input logic [4:0] i, input logic exp, input string req);
      @(negedge clk);
      acc_req = 1'b1; acc_idx = i;
      @(negedge clk);
      acc_req = 1'b0;
      check(req, {31'b0, acc_err}, {31'b0, exp});
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq", {31'b0, ovf_irq}, 32'h0);
      check("R1 active", cnt_active, 32'h0);
      check("R1 flags", {27'b0, evt_long, cyc_long, evt_reset, cyc_reset, acc_err}, 32'h0);
      rd_reg(3'd0, rd); check("R1 ctrl", rd, 32'h0000_0600);
      rd_reg(3'd1, rd); check("R1 en", rd, 32'h0);

      for (int k = 0; k < 16; k++) begin
         if (VEC[k][67]) wr(VEC[k][66:64], VEC[k][63:32]);
         else begin
            rd_reg(VEC[k][66:64], rd);
            check($sformatf("R7 R11 vector %0d", k), rd, VEC[k][31:0]);
         end
      end

      // state: ctrl off, en=8000003A, ie=80000002, ovf=3
      check("R3 irq gated off", {31'b0, ovf_irq}, 32'h0);
      check("R2 active gated off", cnt_active, 32'h0);
      wr(3'd0, 32'h1);
      check("R3 irq on", {31'b0, ovf_irq}, 32'h1);
      check("R2 active on", cnt_active, 32'h8000_003A);
      wr(3'd4, 32'h2);
      check("R3 irq cleared", {31'b0, ovf_irq}, 32'h0);

      // R10 hardware overflow, legal and illegal bits
      @(negedge clk); hw_ovf = 32'h8010_0000;
      @(negedge clk); hw_ovf = '0;
      check("R10 irq from hw", {31'b0, ovf_irq}, 32'h1);
      rd_reg(3'd3, rd); check("R10 R8 ovf mask", rd, 32'h8000_0001);

      // R10 hw set beats clear in same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0000_0001; hw_ovf = 32'h1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0; hw_ovf = '0;
      rd_reg(3'd3, rd); check("R10 set wins", rd, 32'h8000_0001);

      // R5 reset pulses
      wr(3'd0, 32'h3);
      check("R5 evt pulse", {30'b0, evt_reset, cyc_reset}, 32'h2);
      @(negedge clk);
      check("R5 evt pulse drop", {30'b0, evt_reset, cyc_reset}, 32'h0);
      wr(3'd0, 32'h5);
      check("R5 cyc pulse", {30'b0, evt_reset, cyc_reset}, 32'h1);
      check("R2 enable kept", cnt_active, 32'h8000_003A);
      @(negedge clk);
      check("R5 cyc pulse drop", {30'b0, evt_reset, cyc_reset}, 32'h0);

      // R6 width selects
      wr(3'd0, 32'h9);
      check("R6 evt long", {30'b0, evt_long, cyc_long}, 32'h2);
      wr(3'd0, 32'h11);
      check("R6 cyc long", {30'b0, evt_long, cyc_long}, 32'h1);

      // R9 index probes
      probe(5'd5,  1'b0, "R9 idx 5");
      probe(5'd6,  1'b1, "R9 idx 6");
      probe(5'd30, 1'b1, "R9 idx 30");
      probe(5'd31, 1'b0, "R9 idx 31");
      @(negedge clk); acc_idx = 5'd20;
      @(negedge clk);
      check("R9 no request", {31'b0, acc_err}, 32'h0);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq after reset", {31'b0, ovf_irq}, 32'h0);
      check("R1 active after reset", cnt_active, 32'h0);
      check("R1 long after reset", {30'b0, evt_long, cyc_long}, 32'h0);
      rd_reg(3'd0, rd); check("R1 ctrl after reset", rd, 32'h0000_0600);
      rd_reg(3'd3, rd); check("R1 ovf after reset", rd, 32'h0);
      rd_reg(3'd5, rd); check("R1 ie after reset", rd, 32'h0);

      finish_run();
   end
endmodule